// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

The block joins two buses of equal width, called A and B, with one storage element in each direction. A-to-B traffic and B-to-A traffic each have their own enable, latch-enable and capture-clock controls. The storage in each direction works in one of three ways. With latch-enable high it is a transparent latch. With latch-enable low and no rising capture-clock edge it holds its value. With latch-enable low it also works as an edge-triggered register that loads on each rising capture-clock edge. Each direction drives its destination bus through an output stage that can be switched off.

The block is written for a synchronous chip fabric. Every control input is sampled on the system clock `clk`. A rising edge of a capture clock is detected when two successive `clk` samples of that clock go from 0 to 1. The transparent path is combinational. While latch-enable is high, the destination output follows the source input in the same cycle. Each bus is split into an input vector, an output vector and a drive flag. When the drive flag is low the output vector is all zeros, and the surrounding logic treats the bus as released. Contention between the two directions is left to the user.

Top module: `uni_bus_xcvr`

## Requirements
- R1: While `ab_le` is 1 and the A-to-B direction is enabled, `b_out` equals `a_in` in the same cycle, with no clock edge needed. The same holds for `ba_le`, `a_out` and `b_in`.
- R2: While latch-enable is 0 and no rising capture-clock edge is sampled, the stored value does not change. This covers a steady clock at either level and a falling clock edge. The destination output keeps showing the stored value even when the source input changes.
- R3: While latch-enable is 0, a capture clock sampled 0 at one `clk` edge and 1 at the next loads the source input present at that second `clk` edge. The destination output shows the loaded value from that edge on.
- R4: The A-to-B enable `ab_oe` is active high. When it is 0, `b_out` is all zeros and `b_drive` is 0. The stored A-to-B value is kept and reappears when the enable returns to 1.
- R5: The B-to-A enable `ba_oe_n` is active low. When it is 1, `a_out` is all zeros and `a_drive` is 0. The stored B-to-A value is kept and reappears when the enable returns to 0.
- R6: When latch-enable goes from 1 to 0, the value held afterwards is the source input present at the last `clk` edge at which latch-enable was still 1. This applies whatever the level of the capture clock.
- R7: A rising capture-clock edge while latch-enable is 1 has no effect beyond the transparent pass-through.
- R8: The two directions share no storage. Activity on one direction's controls and input never changes what the other direction holds.
- R9: With the `HAS_RESET` parameter at 1 (the default), `srst` high at a `clk` edge clears both stored values to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all controls sampled on its rising edge |
| srst | input | 1 | Synchronous reset, active high |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_ck | input | 1 | A-to-B capture clock |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_ck | input | 1 | B-to-A capture clock |
| a_in | input | W | Value read from bus A |
| a_out | output | W | Value driven onto bus A (zero when released) |
| a_drive | output | 1 | 1 while bus A is driven |
| b_in | input | W | Value read from bus B |
| b_out | output | W | Value driven onto bus B (zero when released) |
| b_drive | output | 1 | 1 while bus B is driven |

## Verification
The hardest case to reach is the latch-enable fall while the capture clock is already high. No new edge may then load a fresh value, and the held word must be the one present just before the fall. The stimulus raises the capture clock and keeps latch-enable high for a full cycle. It then drops latch-enable and changes the source in the next cycle. A later falling and a later rising capture-clock edge separate the hold case from the capture case. Each direction is exercised while the other holds a distinct word, so any sharing of storage shows up.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    XM_HOLD = 2'd0,
    XM_PASS = 2'd1,
    XM_EDGE = 2'd2
  } xfer_mode_e;

  // Latch enable wins over a sampled rising edge; otherwise hold.
  function automatic xfer_mode_e pick_mode(input logic le, input logic rise);
    if (le)        return XM_PASS;
    else if (rise) return XM_EDGE;
    else           return XM_HOLD;
  endfunction

endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk,
  input  logic srst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (srst)
    rise |=> !rise); // R3

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int W         = 18,
  parameter bit HAS_RESET = 1'b1
) (
  input  logic         clk,
  input  logic         srst,
  input  xfer_mode_e   mode,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    case (mode)
      XM_PASS: q_next = d;
      XM_EDGE: q_next = d;
      default: q_next = q;
    endcase
  end

  generate
    if (HAS_RESET) begin : g_rst
      always_ff @(posedge clk) begin
        if (srst) q <= '0;
        else      q <= q_next;
      end

      AST_RESET_CLEAR: assert property (@(posedge clk)
        srst |=> (q == '0)); // R9
    end else begin : g_norst
      always_ff @(posedge clk) begin
        q <= q_next;
      end
    end
  endgenerate

endmodule

// File: rtl/xcvr_out_stage.sv
module xcvr_out_stage #(
  parameter int W = 18
) (
  input  logic         en,
  input  logic         le,
  input  logic [W-1:0] d,
  input  logic [W-1:0] store_q,
  output logic [W-1:0] q,
  output logic         drive
);
  logic [W-1:0] view;

  assign view  = le ? d : store_q;
  assign q     = en ? view : '0;
  assign drive = en;

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W             = 18,
  parameter bit EN_ACTIVE_LOW = 1'b0,
  parameter bit HAS_RESET     = 1'b1
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         en_pin,
  input  logic         le,
  input  logic         ck,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         drive
);
  logic         en;
  logic         ck_rise;
  xfer_mode_e   mode;
  logic [W-1:0] store_q;

  generate
    if (EN_ACTIVE_LOW) begin : g_en_low
      assign en = ~en_pin;
    end else begin : g_en_high
      assign en = en_pin;
    end
  endgenerate

  xcvr_edge_det u_edge (
    .clk  (clk),
    .srst (srst),
    .lvl  (ck),
    .rise (ck_rise)
  );

  assign mode = pick_mode(le, ck_rise);

  xcvr_store #(.W(W), .HAS_RESET(HAS_RESET)) u_store (
    .clk  (clk),
    .srst (srst),
    .mode (mode),
    .d    (d),
    .q    (store_q)
  );

  xcvr_out_stage #(.W(W)) u_out (
    .en      (en),
    .le      (le),
    .d       (d),
    .store_q (store_q),
    .q       (q),
    .drive   (drive)
  );

  AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (srst)
    (le && drive) |-> (q == d)); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (srst)
    (!le && !ck_rise) |=> $stable(store_q)); // R2

  AST_EDGE_LOADS: assert property (@(posedge clk) disable iff (srst)
    (!le && ck_rise) |=> (store_q == $past(d))); // R3

  AST_FALL_KEEPS: assert property (@(posedge clk) disable iff (srst)
    (le && !$past(srst)) |=> (store_q == $past(d))); // R6

  AST_RISE_NO_EXTRA: assert property (@(posedge clk) disable iff (srst)
    (le && ck_rise) |=> (store_q == $past(d))); // R7

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (srst)
    (en_pin == EN_ACTIVE_LOW) |-> (q == '0 && !drive)); // R4

endmodule

// File: rtl/uni_bus_xcvr.sv
module uni_bus_xcvr #(
  parameter int W         = 18,
  parameter bit HAS_RESET = 1'b1
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         ab_oe,
  input  logic         ab_le,
  input  logic         ab_ck,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_ck,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drive
);

  xcvr_lane #(.W(W), .EN_ACTIVE_LOW(1'b0), .HAS_RESET(HAS_RESET)) u_ab (
    .clk    (clk),
    .srst   (srst),
    .en_pin (ab_oe),
    .le     (ab_le),
    .ck     (ab_ck),
    .d      (a_in),
    .q      (b_out),
    .drive  (b_drive)
  );

  xcvr_lane #(.W(W), .EN_ACTIVE_LOW(1'b1), .HAS_RESET(HAS_RESET)) u_ba (
    .clk    (clk),
    .srst   (srst),
    .en_pin (ba_oe_n),
    .le     (ba_le),
    .ck     (ba_ck),
    .d      (b_in),
    .q      (a_out),
    .drive  (a_drive)
  );

  AST_BA_POLARITY: assert property (@(posedge clk) disable iff (srst)
    ba_oe_n |-> (!a_drive && a_out == '0)); // R5

  AST_AB_POLARITY: assert property (@(posedge clk) disable iff (srst)
    !ab_oe |-> (!b_drive && b_out == '0)); // R4

endmodule

// File: tb/uni_bus_xcvr_test.sv
module uni_bus_xcvr_test;
  localparam int W = 18;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic ab_oe = 1'b0, ab_le = 1'b0, ab_ck = 1'b0;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_ck = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_drive, b_drive;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  uni_bus_xcvr #(.W(W)) uut (
    .clk(clk), .srst(srst),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_ck(ab_ck),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_ck(ba_ck),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    srst = 1'b1; tick(); tick(); srst = 1'b0;
    ab_oe = 1'b1; ba_oe_n = 1'b0; #1;
    chk("R9 b_out after reset", b_out, '0);
    chk("R9 a_out after reset", a_out, '0);
    chk("R4 b_drive on", {17'd0, b_drive}, 18'd1);
    chk("R5 a_drive on", {17'd0, a_drive}, 18'd1);
  endtask

  task automatic t_pass_ab();
    ab_le = 1'b1; a_in = 18'h2A5C3; #1;
    chk("R1 pass A->B", b_out, 18'h2A5C3);
    a_in = 18'h15A3C; #1;
    chk("R1 pass A->B same cycle", b_out, 18'h15A3C);
    tick();
    chk("R1 pass A->B after edge", b_out, 18'h15A3C);
  endtask

  task automatic t_fall_hold_ab();
    ab_ck = 1'b1; a_in = 18'h3F00F; tick();
    ab_le = 1'b0; tick();
    a_in = 18'h00FF0; #1;
    chk("R6 fall with clock high", b_out, 18'h3F00F);
    ab_ck = 1'b0; tick(); tick();
    chk("R2 falling clock holds", b_out, 18'h3F00F);
  endtask

  task automatic t_capture_ab();
    a_in = 18'h1B2D4; tick();
    chk("R2 low clock holds", b_out, 18'h3F00F);
    ab_ck = 1'b1; tick();
    chk("R3 rising edge loads", b_out, 18'h1B2D4);
    a_in = 18'h0C3E1; tick(); tick();
    chk("R2 high clock holds", b_out, 18'h1B2D4);
  endtask

  task automatic t_oe_ab();
    ab_oe = 1'b0; #1;
    chk("R4 released b_out", b_out, '0);
    chk("R4 released b_drive", {17'd0, b_drive}, '0);
    tick(); ab_oe = 1'b1; #1;
    chk("R4 value kept", b_out, 18'h1B2D4);
  endtask

  task automatic t_rise_le_ab();
    ab_ck = 1'b0; tick();
    a_in = 18'h2468A; ab_le = 1'b1; tick();
    ab_ck = 1'b1; tick();
    ab_le = 1'b0; a_in = 18'h13579; tick();
    chk("R7 edge under transparency", b_out, 18'h2468A);
  endtask

  task automatic t_ba();
    ba_le = 1'b1; b_in = 18'h3C3C3; #1;
    chk("R1 pass B->A", a_out, 18'h3C3C3);
    tick(); ba_le = 1'b0; tick();
    b_in = 18'h11111; #1;
    chk("R6 B->A fall holds", a_out, 18'h3C3C3);
    ba_ck = 1'b1; tick();
    chk("R3 B->A edge loads", a_out, 18'h11111);
    b_in = 18'h22222; ba_ck = 1'b0; tick(); tick();
    chk("R2 B->A hold", a_out, 18'h11111);
    ba_oe_n = 1'b1; #1;
    chk("R5 released a_out", a_out, '0);
    chk("R5 released a_drive", {17'd0, a_drive}, '0);
    tick(); ba_oe_n = 1'b0; #1;
    chk("R5 value kept", a_out, 18'h11111);
    chk("R8 A->B untouched by B->A", b_out, 18'h2468A);
  endtask

  task automatic t_indep();
    ab_ck = 1'b0; a_in = 18'h0ABCD; tick();
    ab_ck = 1'b1; tick();
    chk("R8 A->B loads", b_out, 18'h0ABCD);
    chk("R8 B->A untouched by A->B", a_out, 18'h11111);
  endtask

  task automatic t_reset_clear();
    srst = 1'b1; tick(); srst = 1'b0; #1;
    chk("R9 clears A->B", b_out, '0);
    chk("R9 clears B->A", a_out, '0);
  endtask

  initial begin
    t_reset();
    t_pass_ab();
    t_fall_hold_ab();
    t_capture_ab();
    t_oe_ab();
    t_rise_le_ab();
    t_ba();
    t_indep();
    t_reset_clear();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule